// File: doc/BRIEF.md
# Home Directory Engine for Migrating Copies

This block is the home-side directory engine for a write-invalidate coherence protocol. In this protocol, data copies migrate between nodes and the memory level behaves as another level of cache. The engine keeps one entry per memory block. An entry holds a presence bitmap with one bit per node, a 2-bit stable state (invalid, shared, exclusive) and a master pointer. The master pointer names the node that holds the master copy or the exclusive copy.

Coherence messages arrive on a single request port, at most one per cycle. Each request produces at most one registered reply, one cycle later. The reply goes either on a response port that carries a destination node ID, or on an invalidation port that carries a multicast node mask.

Read misses are not served from home when a copy exists. They are forwarded to the current master, and the requester becomes the new master. Write misses invalidate every other holder and are granted only after all acknowledgements have been collected. When the master copy is evicted, the engine either promotes a remaining sharer or hands the data to a candidate node named in the eviction message. One engine context tracks the single transaction that is waiting for acknowledgements. While it is busy, conflicting requests are refused with a NACK so that the sender retries.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is invalid with an empty bitmap, and both output valids are low. Request type codes: 0 read miss, 1 write miss, 2 replacement, 3 acknowledgement.
- R2: A read miss (type 0) to an invalid block answers the requester with shared grant code 1. The entry becomes shared, with the requester as master and as the only presence bit.
- R3: A read miss to a shared or exclusive block sends forward code 3 to the old master, with the origin field set to the requester. The requester becomes master, its presence bit is set, and the state becomes shared.
- R4: A write miss (type 1) with no other holder answers at once with exclusive grant code 2. "No other holder" means the block is invalid, or its only presence bit is the requester's. The entry becomes exclusive, with the requester as master and as the only presence bit.
- R5: A write miss with other holders drives one invalidation whose mask is the bitmap minus the requester, with no response in that cycle. The block then turns transient.
- R6: Exclusive grant code 2 to the write requester follows the acknowledgement (type 3) that brings the pending count, loaded with the popcount of the invalidation mask, to zero. Acknowledgements for other blocks, or with nothing pending, produce no output and do not count. After the grant the entry is exclusive, with the requester as master and sole holder.
- R7: A replacement (type 2) from a node that is not the master clears that node's presence bit and produces no output.
- R8: A replacement by the master while other presence bits are set sends new-master code 4 to the lowest-numbered remaining sharer. That node becomes master, and the block stays transient until that node acknowledges.
- R9: A replacement by the master with no other sharer sends forward-data code 5 to the node in the auxiliary field. That node becomes master and sole holder in the shared state, and the block stays transient until it acknowledges.
- R10: A read, write or replacement to a transient block is answered with NACK code 0 to its sender. A request that would open a second transient transaction (R5, R8, R9) while another block is transient is also answered with NACK code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_type_i | input | 2 | Request type code |
| req_src_i | input | NW | Sending node |
| req_blk_i | input | BW | Block index |
| req_aux_i | input | NW | Candidate node for a last-copy eviction |
| rsp_valid_o | output | 1 | Response present |
| rsp_type_o | output | 3 | Response code |
| rsp_dst_o | output | NW | Destination node |
| rsp_org_o | output | NW | Node that opened the transaction |
| rsp_blk_o | output | BW | Block index |
| inv_valid_o | output | 1 | Invalidation multicast present |
| inv_mask_o | output | NODES | Nodes to invalidate |
| inv_blk_o | output | BW | Block index of the invalidation |

## Verification
Two things can fall in the same cycle. One is the last acknowledgement that releases a pending write grant; the other is fresh traffic to other blocks, which the engine must keep serving while it waits. The refusal rule decides between serving and NACKing that traffic. The bench interleaves correct and stray acknowledgements with read misses, write misses and evictions spread over a few colliding blocks. It judges every reply against a directory model built from the requirements. This covers whether traffic to the busy block is refused, whether unrelated reads are served, and whether the grant appears exactly on the count-closing acknowledgement.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;
  typedef enum logic [1:0] {DS_INV = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dir_state_e;
  typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_REPL = 2'd2, RQ_ACK = 2'd3} req_kind_e;
  typedef enum logic [2:0] {
    RS_NACK = 3'd0, RS_GNT_SH = 3'd1, RS_GNT_EX = 3'd2,
    RS_FWD_RD = 3'd3, RS_NEW_MST = 3'd4, RS_REPL_FWD = 3'd5
  } rsp_kind_e;
  typedef enum logic {TX_INVAL = 1'b0, TX_MOVE = 1'b1} tx_kind_e;
endpackage

// File: rtl/home_dir_store.sv
module home_dir_store #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BW-1:0]    rd_blk_i,
  output logic [NODES-1:0] rd_pres_o,
  output logic [1:0]       rd_state_o,
  output logic [NW-1:0]    rd_mst_o,
  input  logic             wr_en_i,
  input  logic [BW-1:0]    wr_blk_i,
  input  logic [NODES-1:0] wr_pres_i,
  input  logic [1:0]       wr_state_i,
  input  logic [NW-1:0]    wr_mst_i
);
  logic [NODES-1:0] pres_q  [BLOCKS];
  logic [1:0]       state_q [BLOCKS];
  logic [NW-1:0]    mst_q   [BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) begin
        pres_q[b]  <= '0;
        state_q[b] <= '0;
        mst_q[b]   <= '0;
      end
    end else if (wr_en_i) begin
      pres_q[wr_blk_i]  <= wr_pres_i;
      state_q[wr_blk_i] <= wr_state_i;
      mst_q[wr_blk_i]   <= wr_mst_i;
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_state_o = state_q[rd_blk_i];
  assign rd_mst_o   = mst_q[rd_blk_i];
endmodule

// File: rtl/home_dir_bitops.sv
module home_dir_bitops #(
  parameter int NODES = 4,
  localparam int NW = $clog2(NODES)
) (
  input  logic [NODES-1:0] mask_i,
  output logic             any_o,
  output logic [NW-1:0]    low_o,
  output logic [NW:0]      pop_o
);
  always_comb begin
    any_o = 1'b0;
    low_o = '0;
    pop_o = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        any_o = 1'b1;
        low_o = NW'(i);
      end
      pop_o = pop_o + (NW + 1)'(mask_i[i]);
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import home_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_type_i,
  input  logic [NW-1:0]    req_src_i,
  input  logic [BW-1:0]    req_blk_i,
  input  logic [NW-1:0]    req_aux_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_type_o,
  output logic [NW-1:0]    rsp_dst_o,
  output logic [NW-1:0]    rsp_org_o,
  output logic [BW-1:0]    rsp_blk_o,
  output logic             inv_valid_o,
  output logic [NODES-1:0] inv_mask_o,
  output logic [BW-1:0]    inv_blk_o
);
  logic [NODES-1:0] cur_pres, wr_pres, others, src_bit;
  logic [1:0]       cur_st_raw;
  dir_state_e       cur_st, wr_st;
  logic [NW-1:0]    cur_mst, wr_mst, oth_low;
  logic [NW:0]      oth_pop;
  logic             oth_any, wr_en, blk_hold, is_master;
  req_kind_e        kind;

  // single transaction context
  logic          busy_q, busy_d;
  tx_kind_e      tx_q, tx_d;
  logic [BW-1:0] pblk_q, pblk_d;
  logic [NW-1:0] pnode_q, pnode_d;
  logic [NW:0]   cnt_q, cnt_d;

  logic             rv_d, iv_d;
  rsp_kind_e        rt_d;
  logic [NW-1:0]    rdst_d, rorg_d;
  logic [NODES-1:0] im_d;

  home_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
    .clk_i, .rst_ni,
    .rd_blk_i(req_blk_i), .rd_pres_o(cur_pres), .rd_state_o(cur_st_raw), .rd_mst_o(cur_mst),
    .wr_en_i(wr_en), .wr_blk_i(req_blk_i), .wr_pres_i(wr_pres),
    .wr_state_i(wr_st), .wr_mst_i(wr_mst)
  );

  home_dir_bitops #(.NODES(NODES)) u_bits (
    .mask_i(others), .any_o(oth_any), .low_o(oth_low), .pop_o(oth_pop)
  );

  assign cur_st    = dir_state_e'(cur_st_raw);
  assign kind      = req_kind_e'(req_type_i);
  assign src_bit   = NODES'(1) << req_src_i;
  assign others    = cur_pres & ~src_bit;
  assign blk_hold  = busy_q && (pblk_q == req_blk_i);
  assign is_master = (cur_st != DS_INV) && (cur_mst == req_src_i);

  always_comb begin
    wr_en = 1'b0; wr_pres = cur_pres; wr_st = cur_st; wr_mst = cur_mst;
    rv_d = 1'b0; rt_d = RS_NACK; rdst_d = req_src_i; rorg_d = req_src_i;
    iv_d = 1'b0; im_d = '0;
    busy_d = busy_q; tx_d = tx_q; pblk_d = pblk_q; pnode_d = pnode_q; cnt_d = cnt_q;
    if (req_valid_i) begin
      unique case (kind)
        RQ_RD: begin
          if (blk_hold) rv_d = 1'b1;
          else begin
            wr_en = 1'b1; wr_st = DS_SHR; wr_mst = req_src_i; rv_d = 1'b1;
            if (cur_st == DS_INV) begin
              wr_pres = src_bit; rt_d = RS_GNT_SH;
            end else begin
              wr_pres = cur_pres | src_bit; rt_d = RS_FWD_RD; rdst_d = cur_mst;
            end
          end
        end
        RQ_WR: begin
          if (blk_hold) rv_d = 1'b1;
          else if (!oth_any) begin
            wr_en = 1'b1; wr_st = DS_EXC; wr_mst = req_src_i; wr_pres = src_bit;
            rv_d = 1'b1; rt_d = RS_GNT_EX;
          end else if (busy_q) rv_d = 1'b1;
          else begin
            iv_d = 1'b1; im_d = others;
            busy_d = 1'b1; tx_d = TX_INVAL; pblk_d = req_blk_i; pnode_d = req_src_i; cnt_d = oth_pop;
          end
        end
        RQ_REPL: begin
          if (blk_hold) rv_d = 1'b1;
          else if (!is_master) begin
            wr_en = 1'b1; wr_pres = others;
          end else if (busy_q) rv_d = 1'b1;
          else begin
            wr_en = 1'b1; wr_st = DS_SHR; rv_d = 1'b1;
            busy_d = 1'b1; tx_d = TX_MOVE; pblk_d = req_blk_i;
            if (oth_any) begin
              wr_pres = others; wr_mst = oth_low; rt_d = RS_NEW_MST; rdst_d = oth_low;
              pnode_d = oth_low;
            end else begin
              wr_pres = NODES'(1) << req_aux_i; wr_mst = req_aux_i;
              rt_d = RS_REPL_FWD; rdst_d = req_aux_i; pnode_d = req_aux_i;
            end
          end
        end
        default: begin // acknowledgement
          if (blk_hold) begin
            if (tx_q == TX_MOVE) begin
              if (req_src_i == pnode_q) busy_d = 1'b0;
            end else if (cnt_q == (NW + 1)'(1)) begin
              wr_en = 1'b1; wr_st = DS_EXC; wr_mst = pnode_q; wr_pres = NODES'(1) << pnode_q;
              rv_d = 1'b1; rt_d = RS_GNT_EX; rdst_d = pnode_q; rorg_d = pnode_q;
              busy_d = 1'b0;
            end else cnt_d = cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; tx_q <= TX_INVAL; pblk_q <= '0; pnode_q <= '0; cnt_q <= '0;
      rsp_valid_o <= 1'b0; rsp_type_o <= '0; rsp_dst_o <= '0; rsp_org_o <= '0; rsp_blk_o <= '0;
      inv_valid_o <= 1'b0; inv_mask_o <= '0; inv_blk_o <= '0;
    end else begin
      busy_q <= busy_d; tx_q <= tx_d; pblk_q <= pblk_d; pnode_q <= pnode_d; cnt_q <= cnt_d;
      rsp_valid_o <= rv_d; rsp_type_o <= rt_d; rsp_dst_o <= rdst_d; rsp_org_o <= rorg_d;
      rsp_blk_o <= req_blk_i;
      inv_valid_o <= iv_d; inv_mask_o <= im_d; inv_blk_o <= req_blk_i;
    end
  end
endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  localparam int NW = $clog2(NODES),
  localparam int BW = $clog2(BLOCKS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_type_i,
  input logic [NW-1:0]    req_src_i,
  input logic [BW-1:0]    req_blk_i,
  input logic             rsp_valid_o,
  input logic [2:0]       rsp_type_o,
  input logic [NW-1:0]    rsp_dst_o,
  input logic [NW-1:0]    rsp_org_o,
  input logic             inv_valid_o,
  input logic [NODES-1:0] inv_mask_o
);
  a_r1_single_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && inv_valid_o));

  a_r10_nack_to_sender: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == 3'd0) |->
      ($past(req_valid_i) && $past(req_type_i) != 2'd3 && rsp_dst_o == $past(req_src_i)));

  a_r5_inval_skips_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> ($past(req_type_i) == 2'd1 && !inv_mask_o[$past(req_src_i)]
                     && $countones(inv_mask_o) >= 1));

  a_r6_grant_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == 3'd2) |->
      ($past(req_valid_i) && ($past(req_type_i) == 2'd1 || $past(req_type_i) == 2'd3)));

  a_r3_forward_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == 3'd3) |->
      ($past(req_type_i) == 2'd0 && rsp_org_o == $past(req_src_i)));

  a_r8_new_master_elsewhere: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_type_o == 3'd4) |->
      ($past(req_type_i) == 2'd2 && rsp_dst_o != $past(req_src_i)));
endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_type_i(req_type_i),
  .req_src_i(req_src_i), .req_blk_i(req_blk_i), .rsp_valid_o(rsp_valid_o),
  .rsp_type_o(rsp_type_o), .rsp_dst_o(rsp_dst_o), .rsp_org_o(rsp_org_o),
  .inv_valid_o(inv_valid_o), .inv_mask_o(inv_mask_o)
);

// File: tb/home_dir_ctrl_tb.sv
module home_dir_ctrl_tb;
  localparam int N  = 4;
  localparam int B  = 16;
  localparam int NW = 2;
  localparam int BW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [NW-1:0] req_src = '0, req_aux = '0;
  logic [BW-1:0] req_blk = '0;
  logic rsp_valid, inv_valid;
  logic [2:0] rsp_type;
  logic [NW-1:0] rsp_dst, rsp_org;
  logic [BW-1:0] rsp_blk, inv_blk;
  logic [N-1:0] inv_mask;

  always #2 clk = ~clk;

  home_dir_ctrl #(.NODES(N), .BLOCKS(B)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_src_i(req_src), .req_blk_i(req_blk), .req_aux_i(req_aux),
    .rsp_valid_o(rsp_valid), .rsp_type_o(rsp_type), .rsp_dst_o(rsp_dst),
    .rsp_org_o(rsp_org), .rsp_blk_o(rsp_blk), .inv_valid_o(inv_valid),
    .inv_mask_o(inv_mask), .inv_blk_o(inv_blk)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference directory
  logic [N-1:0] m_pres [B];
  int m_st [B];
  int m_mst [B];
  bit m_busy, m_move;
  int m_blk, m_node, m_cnt;

  bit e_rv, e_iv;
  int e_rt, e_rd, e_ro, e_rb;
  logic [N-1:0] e_im;
  string e_tag;

  function automatic int low_bit(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int pop(logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic reply(input int t, input int d, input int o, input int b);
    e_rv = 1; e_rt = t; e_rd = d; e_ro = o; e_rb = b;
  endtask

  task automatic model(input int t, input int s, input int b, input int a);
    logic [N-1:0] oth;
    bit hold;
    oth  = m_pres[b] & ~(N'(1) << s);
    hold = m_busy && m_blk == b;
    e_rv = 0; e_iv = 0; e_im = '0;
    if (t == 0) begin
      if (hold) begin reply(0, s, s, b); e_tag = "R10"; end
      else if (m_st[b] == 0) begin
        reply(1, s, s, b); m_st[b] = 1; m_mst[b] = s; m_pres[b] = N'(1) << s; e_tag = "R2";
      end else begin
        reply(3, m_mst[b], s, b); m_st[b] = 1; m_mst[b] = s;
        m_pres[b] = m_pres[b] | (N'(1) << s); e_tag = "R3";
      end
    end else if (t == 1) begin
      if (hold) begin reply(0, s, s, b); e_tag = "R10"; end
      else if (oth == '0) begin
        reply(2, s, s, b); m_st[b] = 2; m_mst[b] = s; m_pres[b] = N'(1) << s; e_tag = "R4";
      end else if (m_busy) begin reply(0, s, s, b); e_tag = "R10"; end
      else begin
        e_iv = 1; e_im = oth; e_rb = b;
        m_busy = 1; m_move = 0; m_blk = b; m_node = s; m_cnt = pop(oth); e_tag = "R5";
      end
    end else if (t == 2) begin
      if (hold) begin reply(0, s, s, b); e_tag = "R10"; end
      else if (!(m_st[b] != 0 && m_mst[b] == s)) begin m_pres[b] = oth; e_tag = "R7"; end
      else if (m_busy) begin reply(0, s, s, b); e_tag = "R10"; end
      else begin
        m_busy = 1; m_move = 1; m_blk = b; m_st[b] = 1;
        if (oth != '0) begin
          m_node = low_bit(oth); reply(4, m_node, s, b);
          m_pres[b] = oth; m_mst[b] = m_node; e_tag = "R8";
        end else begin
          m_node = a; reply(5, a, s, b);
          m_pres[b] = N'(1) << a; m_mst[b] = a; e_tag = "R9";
        end
      end
    end else begin
      e_tag = "R6";
      if (hold) begin
        if (m_move) begin if (s == m_node) m_busy = 0; end
        else if (m_cnt == 1) begin
          reply(2, m_node, m_node, b); m_st[b] = 2; m_mst[b] = m_node;
          m_pres[b] = N'(1) << m_node; m_busy = 0;
        end else m_cnt--;
      end
    end
  endtask

  task automatic check(input string tag);
    bit bad;
    n_vec++;
    bad = (rsp_valid !== e_rv) || (inv_valid !== e_iv);
    if (e_rv && !bad)
      bad = (int'(rsp_type) != e_rt) || (int'(rsp_dst) != e_rd) ||
            (int'(rsp_org) != e_ro) || (int'(rsp_blk) != e_rb);
    if (e_iv && !bad) bad = (inv_mask !== e_im) || (int'(inv_blk) != e_rb);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got rv=%0b t=%0d d=%0d o=%0d b=%0d iv=%0b m=%b | exp rv=%0b t=%0d d=%0d o=%0d b=%0d iv=%0b m=%b",
               tag, rsp_valid, rsp_type, rsp_dst, rsp_org, rsp_blk, inv_valid, inv_mask,
               e_rv, e_rt, e_rd, e_ro, e_rb, e_iv, e_im);
    end
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic op(input int t, input int s, input int b, input int a);
    req_valid = 1; req_type = 2'(t); req_src = NW'(s); req_blk = BW'(b); req_aux = NW'(a);
    model(t, s, b, a);
    @(negedge clk);
    check(e_tag);
  endtask

  task automatic idle();
    req_valid = 0;
    e_rv = 0; e_iv = 0;
    @(negedge clk);
    check("R1");
  endtask

  initial begin
    logic [15:0] lf;
    int t, s, b, a;
    for (int i = 0; i < B; i++) begin m_pres[i] = '0; m_st[i] = 0; m_mst[i] = 0; end
    m_busy = 0; m_move = 0; m_blk = 0; m_node = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle(); // R1 reset outputs quiet
    // directed corners
    op(0, 1, 0, 0);  // R2
    op(0, 2, 0, 0);  // R3 forward to 1
    op(0, 3, 0, 0);  // R3 forward to 2
    op(1, 0, 0, 0);  // R5 invalidate 1,2,3
    op(0, 1, 0, 0);  // R10 busy block
    op(1, 1, 1, 0);  // R4 idle block served
    op(0, 2, 3, 0);  // R2 other block served while busy
    op(0, 0, 3, 0);  // R3
    op(1, 1, 3, 0);  // R10 second transient refused
    op(3, 1, 1, 0);  // R6 stray ack ignored
    op(3, 1, 0, 0);  // R6
    op(3, 2, 0, 0);  // R6
    op(3, 3, 0, 0);  // R6 grant to 0
    op(0, 2, 0, 0);  // R3 forward to owner 0
    op(2, 0, 0, 0);  // R7 non-master eviction
    op(2, 2, 0, 1);  // R9 last copy to node 1
    op(3, 3, 0, 0);  // wrong acker, still busy
    op(2, 1, 0, 2);  // R10
    op(3, 1, 0, 0);  // release
    op(2, 0, 3, 0);  // R8 master 0 evicts, sharer 2 promoted
    op(3, 2, 3, 0);
    op(1, 1, 1, 0);  // R4 owner upgrade
    idle();
    // sweep
    lf = 16'hace1;
    for (int k = 0; k < 6000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b = int'(lf[2:0]) % 5;
      s = int'(lf[5:4]);
      a = int'(lf[7:6]);
      t = int'(lf[9:8]);
      if (m_busy && lf[11]) begin
        t = 3; b = m_blk;
        if (m_move) s = lf[12] ? m_node : s;
        else s = low_bit(m_pres[m_blk] & ~(N'(1) << m_node)) < 0 ? s : s;
      end else if (t == 2 && lf[12]) s = m_mst[b];
      else if (t == 3 && !lf[13]) t = 0;
      op(t, s, b, a);
      if (lf[15:14] == 2'b00) idle();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule